// File: doc/BRIEF.md
# Area Colour Bank Decoder

This block picks a colour for each pixel as the display scan reaches it. The scan logic presents the page (an 8-row band) and the column of the current pixel. The block works out which colour bank holds that pixel, and it reports the 2-bit colour code stored for that bank one clock later.

Only the two top pages are divided into banks. Page 0 carries banks 1 to 16 and page 1 carries banks 17 to 32. In each of these pages the first fifteen banks are 8 columns wide. The last bank is 12 columns wide and runs to the panel edge. Every pixel in pages 2 to 7 takes the colour of bank 0, the background bank. A small register file holds the 33 colour codes. It is loaded through a write port that carries a bank index and a code.

Top module: `colour_bank_decoder`

## Requirements
- R1: After reset every bank code is colour A (2'b00), and `bank_o` and `colour_o` read 0 until the first pixel is registered.
- R2: Page 0 pixels in columns 0 to 119 map to bank `col/8 + 1`. `bank_o` shows the result at the clock edge after the pixel is presented.
- R3: Page 0 columns 120 and above map to bank 16, the 12-column-wide bank.
- R4: Page 1 maps the same way with an offset of 16. Columns 0 to 119 map to `col/8 + 17` and columns 120 and above map to bank 32.
- R5: Pixels in pages 2 to 7 map to bank 0, whatever their column.
- R6: `colour_o` is the code stored for the bank of the registered pixel. The codes are A=2'b00, B=2'b01, C=2'b10 and D=2'b11.
- R7: A write with `wr_en_i` high and `wr_idx_i` from 0 to 32 stores `wr_code_i` at the clock edge. A pixel presented in the same cycle as the write still sees the old code. A pixel presented in the following cycle sees the new code.
- R8: A write whose index is 33 to 63 changes no stored code.
- R9: A write to one bank leaves the codes of all other banks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe for the colour register file |
| wr_idx_i | input | 6 | Bank index to write |
| wr_code_i | input | 2 | Colour code to store |
| page_i | input | 3 | Page of the pixel being scanned |
| col_i | input | 8 | Column of the pixel being scanned |
| bank_o | output | 6 | Bank of the registered pixel |
| colour_o | output | 2 | Colour code of the registered pixel |

## Verification
The bench builds the block with its default parameters: 132 columns, 16 banks per page, 8-column banks and a 12-column last bank. With these values both wide banks are reachable, and a full sweep of all 8 pages across every column covers every boundary between banks. The 6-bit index port lets the bench drive all of the ignored indices from 33 to 63. The bench also places a write and a read of the same bank in one cycle, which exposes the one-cycle order in which a new code becomes visible.

// File: rtl/cbd_pkg.sv
package cbd_pkg;

  typedef enum logic [1:0] {
    COLOUR_A = 2'b00,
    COLOUR_B = 2'b01,
    COLOUR_C = 2'b10,
    COLOUR_D = 2'b11
  } colour_e;

  // Bank of a pixel: banked pages are numbered from bank 1 upward, and the
  // last bank of each banked page absorbs every column past its start.
  function automatic int bank_of(input int page, input int col,
                                 input int banked_pages, input int per_page,
                                 input int narrow);
    int slot;
    if (page >= banked_pages) return 0;
    slot = col / narrow;
    if (slot > per_page - 1) slot = per_page - 1;
    return page * per_page + slot + 1;
  endfunction

endpackage

// File: rtl/cbd_bank_map.sv
module cbd_bank_map #(
  parameter int PAGE_W       = 3,
  parameter int COL_W        = 8,
  parameter int BANK_W       = 6,
  parameter int BANKED_PAGES = 2,
  parameter int PER_PAGE     = 16,
  parameter int NARROW       = 8
) (
  input  logic [PAGE_W-1:0] page_i,
  input  logic [COL_W-1:0]  col_i,
  output logic [BANK_W-1:0] bank_o
);
  import cbd_pkg::*;

  always_comb begin
    bank_o = BANK_W'(bank_of(int'(page_i), int'(col_i),
                             BANKED_PAGES, PER_PAGE, NARROW));
  end

endmodule

// File: rtl/cbd_colour_regs.sv
module cbd_colour_regs #(
  parameter int NUM_BANKS = 33,
  parameter int BANK_W    = 6,
  parameter int CODE_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [BANK_W-1:0] wr_idx_i,
  input  logic [CODE_W-1:0] wr_code_i,
  input  logic [BANK_W-1:0] rd_bank_i,
  output logic [CODE_W-1:0] rd_code_o
);

  logic [NUM_BANKS-1:0][CODE_W-1:0] codes;
  logic wr_accept;   // write with an index inside the file
  logic wr_drop;     // write with an index past the file

  assign wr_accept = wr_en_i && (int'(wr_idx_i) < NUM_BANKS);
  assign wr_drop   = wr_en_i && (int'(wr_idx_i) >= NUM_BANKS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      codes <= '0;
    end else begin
      for (int i = 0; i < NUM_BANKS; i++) begin
        if (wr_accept && wr_idx_i == BANK_W'(i)) codes[i] <= wr_code_i;
      end
    end
  end

  assign rd_code_o = codes[rd_bank_i];

  // R8: an index past the file leaves every code as it was
  assert_drop_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> $stable(codes));

  genvar g;
  for (g = 0; g < NUM_BANKS; g++) begin : g_chk
    // R7: an accepted write lands in its entry
    assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_accept && wr_idx_i == BANK_W'(g)) |=> codes[g] == $past(wr_code_i));
    // R9: entries not addressed keep their code
    assert_others_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_accept && wr_idx_i == BANK_W'(g)) |=> $stable(codes[g]));
  end

endmodule

// File: rtl/colour_bank_decoder.sv
module colour_bank_decoder #(
  parameter int PAGE_W       = 3,
  parameter int COL_W        = 8,
  parameter int CODE_W       = 2,
  parameter int BANKED_PAGES = 2,
  parameter int PER_PAGE     = 16,
  parameter int NARROW       = 8,
  localparam int NUM_BANKS   = BANKED_PAGES * PER_PAGE + 1,
  localparam int BANK_W      = $clog2(NUM_BANKS) < 1 ? 1 : $clog2(NUM_BANKS),
  localparam int WIDE_START  = (PER_PAGE - 1) * NARROW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [BANK_W-1:0] wr_idx_i,
  input  logic [CODE_W-1:0] wr_code_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [COL_W-1:0]  col_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [CODE_W-1:0] colour_o
);

  logic [BANK_W-1:0] pix_bank;
  logic [CODE_W-1:0] pix_code;
  logic              in_background;  // pixel below the banked pages
  logic              in_wide;        // pixel in the last, wide bank of a page

  assign in_background = int'(page_i) >= BANKED_PAGES;
  assign in_wide       = !in_background && int'(col_i) >= WIDE_START;

  cbd_bank_map #(
    .PAGE_W(PAGE_W), .COL_W(COL_W), .BANK_W(BANK_W),
    .BANKED_PAGES(BANKED_PAGES), .PER_PAGE(PER_PAGE), .NARROW(NARROW)
  ) u_map (
    .page_i(page_i), .col_i(col_i), .bank_o(pix_bank)
  );

  cbd_colour_regs #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .CODE_W(CODE_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_code_i(wr_code_i),
    .rd_bank_i(pix_bank), .rd_code_o(pix_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_o   <= '0;
      colour_o <= '0;
    end else begin
      bank_o   <= pix_bank;
      colour_o <= pix_code;
    end
  end

  // R5: lower pages always resolve to the background bank
  assert_background_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_background |=> bank_o == '0);
  // R3, R4: the wide region lands on the last bank of its page
  assert_wide_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_wide |=> int'(bank_o) == (int'($past(page_i)) + 1) * PER_PAGE);
  // R2, R4: a banked pixel never resolves to the background bank
  assert_banked_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_background |=> bank_o != '0);
  // R1: reset clears the outputs
  assert_reset_out_R1: assert property (@(posedge clk)
    !rst_n |=> (bank_o == '0 && colour_o == '0));

endmodule

// File: tb/tb_colour_bank_decoder.sv
module tb_colour_bank_decoder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [5:0] wr_idx_i = '0;
  logic [1:0] wr_code_i = '0;
  logic [2:0] page_i = '0;
  logic [7:0] col_i = '0;
  logic [5:0] bank_o;
  logic [1:0] colour_o;

  int total = 0;
  int bad = 0;
  logic [1:0] shadow [33];

  always #4 clk = ~clk;

  colour_bank_decoder dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
    .wr_code_i(wr_code_i), .page_i(page_i), .col_i(col_i),
    .bank_o(bank_o), .colour_o(colour_o)
  );

  // page, column, expected bank
  localparam int NV = 16;
  localparam int VEC [NV][3] = '{
    '{0, 0, 1},   '{0, 7, 1},    '{0, 8, 2},    '{0, 63, 8},
    '{0, 100, 13},'{0, 119, 15}, '{0, 120, 16}, '{0, 131, 16},
    '{1, 0, 17},  '{1, 15, 18},  '{1, 119, 31}, '{1, 120, 32},
    '{1, 131, 32},'{2, 0, 0},    '{5, 64, 0},   '{7, 131, 0}
  };

  function automatic int ref_bank(int page, int col);
    if (page > 1) return 0;
    if (col >= 120) return 16 + 16 * page;
    return (col >> 3) + 1 + 16 * page;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic show(int page, int col);
    @(negedge clk);
    page_i = 3'(page);
    col_i = 8'(col);
    @(negedge clk);
  endtask

  task automatic wr(int idx, int code);
    @(negedge clk);
    wr_en_i = 1'b1;
    wr_idx_i = 6'(idx);
    wr_code_i = 2'(code);
    if (idx < 33) shadow[idx] = 2'(code);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic sweep_colours(string tag);
    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < 132; c++) begin
        show(p, c);
        chk(tag, int'(colour_o), int'(shadow[ref_bank(p, c)]));
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 33; i++) shadow[i] = 2'b00;
    repeat (3) @(negedge clk);
    chk("R1 bank after reset", int'(bank_o), 0);
    chk("R1 colour after reset", int'(colour_o), 0);
    rst_n = 1'b1;

    // R2 R3 R4 R5: bank lookup table
    for (int v = 0; v < NV; v++) begin
      string tag;
      show(VEC[v][0], VEC[v][1]);
      if (VEC[v][0] > 1) tag = "R5";
      else if (VEC[v][1] >= 120) tag = "R3";
      else if (VEC[v][0] == 1) tag = "R4";
      else tag = "R2";
      chk(tag, int'(bank_o), VEC[v][2]);
      chk("R1 colour A default", int'(colour_o), 0);
    end

    // R6: load distinct codes A/B/C/D and sweep every pixel
    for (int i = 0; i < 33; i++) wr(i, (i * 3 + 1) % 4);
    sweep_colours("R6");

    // R7: write and read of bank 3 in one cycle
    @(negedge clk);
    page_i = 3'd0; col_i = 8'd16;
    wr_en_i = 1'b1; wr_idx_i = 6'd3; wr_code_i = ~shadow[3];
    @(negedge clk);
    wr_en_i = 1'b0;
    chk("R7 same cycle old code", int'(colour_o), int'(shadow[3]));
    shadow[3] = ~shadow[3];
    @(negedge clk);
    chk("R7 next cycle new code", int'(colour_o), int'(shadow[3]));

    // R8: indices past the file are dropped
    wr(33, 2); wr(40, 3); wr(63, 1); wr(48, 0);
    sweep_colours("R8");

    // R9: single write, neighbours untouched
    wr(17, ~shadow[17]);
    show(0, 127); chk("R9 bank16 kept", int'(colour_o), int'(shadow[16]));
    show(1, 0);   chk("R9 bank17 written", int'(colour_o), int'(shadow[17]));
    show(1, 8);   chk("R9 bank18 kept", int'(colour_o), int'(shadow[18]));
    show(3, 5);   chk("R9 bank0 kept", int'(colour_o), int'(shadow[0]));

    // R1: reset mid-run returns every code to A
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 bank in reset", int'(bank_o), 0);
    chk("R1 colour in reset", int'(colour_o), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 33; i++) shadow[i] = 2'b00;
    sweep_colours("R1");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule